// File: doc/BRIEF.md
# Crystal Oscillator Startup Sequencer

This block steps a high-frequency crystal oscillator from off to ready once software sets its enable. It first drives a startup pair of control codes (load-capacitance tune and core bias trim) and keeps them for a programmable startup timeout. It then switches to a steady-state pair and waits a second timeout. Two optional trimming phases may follow. A peak-detection phase raises the bias trim until the measured amplitude reaches a programmable threshold, which lowers noise. A shunt-current phase then lowers the shunt current code for as long as the amplitude stays at or above that threshold, which saves current.

All timeouts count ticks of a reference timebase that arrive on the `tick` input. The analog oscillator sits outside the block. It returns an amplitude measurement code, and the sequencer compares that code against the threshold. When the pin carries a square-wave clock instead of a crystal, external mode zeroes the tune and bias codes. It also shortens both timeouts to the minimum and skips the trimming phases. The outputs are the three live control codes, a phase number and a ready flag.

Top module: `xo_bringup_seq`

## Requirements
- R1: After synchronous reset, `phase_o` is 0, `ready_o` is 0, and `tune_o`, `bias_o` and `shunt_o` are all 0.
- R2: In the clock cycle after `en` is first seen high while idle, `phase_o` is 1. In crystal mode `tune_o`/`bias_o` then equal `start_tune`/`start_bias`, and `shunt_o` equals `shunt_init`.
- R3: A 4-bit timeout code n lasts exactly 2^(n+1) ticks. A cycle with `tick` low never advances a timeout, so with `tick` held low the phase does not change.
- R4: When the startup timeout (`tmo_startup`) expires, `phase_o` becomes 2 and `tune_o`/`bias_o` take `steady_tune`/`steady_bias`. This phase lasts for the `tmo_steady` timeout.
- R5: When `peak_en` is 0, expiry of the steady timeout leads directly to `phase_o` 5 with `ready_o` 1. `ready_o` is high exactly while the phase is 5.
- R6: In phase 3 (peak detection), each tick on which `amp_level < amp_thresh` raises `bias_o` by one. The phase ends on the first tick with `amp_level >= amp_thresh`, or when `tmo_peak` expires (that tick does not step). The reached bias is kept.
- R7: After peak detection, phase 4 (shunt trim) follows only if `shunt_en` is 1, and the phase otherwise becomes 5. In phase 4, each tick with the amplitude at or above threshold lowers `shunt_o` by one. The first tick below threshold raises it by one and ends the phase at 5.
- R8: Phase 4 is never entered unless phase 3 came first: with `peak_en` 0 and `shunt_en` 1, the sequence goes from steady straight to ready and `shunt_o` keeps `shunt_init`.
- R9: With `ext_mode` 1, the tune and bias codes are 0. The startup and steady phases each last 2 ticks whatever their codes are, and both trimming phases are skipped even when enabled.
- R10: When `en` is low at a clock edge, the next cycle shows phase 0, `ready_o` 0 and all codes 0, whatever the phase was. The next enable reloads the startup codes.
- R11: The phase encoding is idle 0, startup 1, steady 2, peak detection 3, shunt trim 4, ready 5.
- R12: The bias trim saturates at its all-ones value during peak detection. The shunt code never wraps below 0: a shunt phase that reaches 0 with the amplitude still at or above threshold ends at 5 with `shunt_o` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Oscillator enable from software |
| ext_mode | input | 1 | 1 = external square-wave clock, 0 = crystal |
| tick | input | 1 | Reference timebase tick, one cycle wide |
| start_tune | input | TUNE_W (8) | Load-capacitance tune code for the startup phase |
| start_bias | input | BIAS_W (6) | Core bias trim for the startup phase |
| steady_tune | input | TUNE_W (8) | Load-capacitance tune code for steady state |
| steady_bias | input | BIAS_W (6) | Core bias trim for steady state |
| shunt_init | input | SHUNT_W (4) | Shunt current code loaded at enable |
| tmo_startup | input | TMO_W (4) | Startup timeout code |
| tmo_steady | input | TMO_W (4) | Steady timeout code |
| tmo_peak | input | TMO_W (4) | Peak-detection timeout code |
| tmo_shunt | input | TMO_W (4) | Shunt-trim timeout code |
| peak_en | input | 1 | Run the peak-detection phase |
| shunt_en | input | 1 | Run the shunt-trim phase after peak detection |
| amp_level | input | AMP_W (8) | Measured oscillation amplitude code |
| amp_thresh | input | AMP_W (8) | Amplitude threshold |
| tune_o | output | TUNE_W (8) | Live tune code |
| bias_o | output | BIAS_W (6) | Live bias trim |
| shunt_o | output | SHUNT_W (4) | Live shunt current code |
| phase_o | output | 3 | Current phase (encoding in R11) |
| ready_o | output | 1 | Oscillator ready |

## Verification
Every output comes from a register. A change of `en`, of the amplitude comparison or of a tick therefore shows up one rising edge after the cycle in which it is present. A timeout of code n produces its phase change on the edge that follows the 2^(n+1)-th tick counted in that phase. The bench drives inputs on the falling edge and steps its reference model on the same rising edge that updates the design. It then compares every output on the next falling edge. The explicit checks count phase lengths in falling edges from the first cycle the new phase is visible, so startup code 2 at one tick per cycle must show exactly eight cycles of phase 1.

// File: rtl/xo_seq_pkg.sv
package xo_seq_pkg;

    typedef enum logic [2:0] {
        PH_IDLE    = 3'd0,
        PH_STARTUP = 3'd1,
        PH_STEADY  = 3'd2,
        PH_PEAK    = 3'd3,
        PH_SHUNT   = 3'd4,
        PH_READY   = 3'd5
    } xo_phase_e;

    typedef enum logic [2:0] {
        CMD_HOLD,
        CMD_CLEAR,
        CMD_START,
        CMD_STEADY,
        CMD_BIAS_UP,
        CMD_SHUNT_DN,
        CMD_SHUNT_UP
    } xo_cmd_e;

    // phase that follows the steady wait
    function automatic xo_phase_e after_steady(input logic peak_on, input logic ext);
        return (peak_on && !ext) ? PH_PEAK : PH_READY;
    endfunction

    // phase that follows peak detection
    function automatic xo_phase_e after_peak(input logic shunt_on);
        return shunt_on ? PH_SHUNT : PH_READY;
    endfunction

endpackage

// File: rtl/xo_phase_timer.sv
module xo_phase_timer #(
    parameter int TMO_W = 4,
    localparam int CNT_W = (1 << TMO_W) + 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart,
    input  logic             tick,
    input  logic [TMO_W-1:0] code,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] last;

    // code n spans 2^(n+1) ticks, so the last count value is 2^(n+1)-1
    assign last   = (CNT_W'(1) << (code + 1)) - CNT_W'(1);
    assign expire = tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart) cnt <= '0;
        else if (tick)      cnt <= cnt + 1'b1;
    end

    AST_TMO_RESTART: assert property (@(posedge clk) disable iff (rst)
        expire |=> (cnt == '0)); // R3

    AST_TMO_NO_TICK: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(cnt)); // R3

endmodule

// File: rtl/xo_amp_cmp.sv
module xo_amp_cmp #(
    parameter int AMP_W = 8
) (
    input  logic [AMP_W-1:0] level,
    input  logic [AMP_W-1:0] thresh,
    output logic             at_or_above
);
    assign at_or_above = (level >= thresh);
endmodule

// File: rtl/xo_trim_path.sv
module xo_trim_path
    import xo_seq_pkg::*;
#(
    parameter int TUNE_W  = 8,
    parameter int BIAS_W  = 6,
    parameter int SHUNT_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  xo_cmd_e            cmd,
    input  logic               ext,
    input  logic [TUNE_W-1:0]  start_tune,
    input  logic [BIAS_W-1:0]  start_bias,
    input  logic [TUNE_W-1:0]  steady_tune,
    input  logic [BIAS_W-1:0]  steady_bias,
    input  logic [SHUNT_W-1:0] shunt_init,
    output logic [TUNE_W-1:0]  tune,
    output logic [BIAS_W-1:0]  bias,
    output logic [SHUNT_W-1:0] shunt
);
    localparam logic [BIAS_W-1:0]  BIAS_MAX  = {BIAS_W{1'b1}};
    localparam logic [SHUNT_W-1:0] SHUNT_MAX = {SHUNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (rst) begin
            tune  <= '0;
            bias  <= '0;
            shunt <= '0;
        end else begin
            unique case (cmd)
                CMD_CLEAR: begin
                    tune  <= '0;
                    bias  <= '0;
                    shunt <= '0;
                end
                CMD_START: begin
                    tune  <= ext ? '0 : start_tune;
                    bias  <= ext ? '0 : start_bias;
                    shunt <= shunt_init;
                end
                CMD_STEADY: begin
                    tune <= ext ? '0 : steady_tune;
                    bias <= ext ? '0 : steady_bias;
                end
                CMD_BIAS_UP: begin
                    if (bias != BIAS_MAX) bias <= bias + 1'b1;
                end
                CMD_SHUNT_DN: begin
                    if (shunt != '0) shunt <= shunt - 1'b1;
                end
                CMD_SHUNT_UP: begin
                    if (shunt != SHUNT_MAX) shunt <= shunt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    AST_EXT_ZERO_CODES: assert property (@(posedge clk) disable iff (rst)
        ((cmd == CMD_START || cmd == CMD_STEADY) && ext) |=> (tune == '0 && bias == '0)); // R9

    AST_BIAS_CEIL: assert property (@(posedge clk) disable iff (rst)
        (bias == BIAS_MAX && cmd != CMD_CLEAR && cmd != CMD_START && cmd != CMD_STEADY)
        |=> (bias == BIAS_MAX)); // R12

endmodule

// File: rtl/xo_bringup_seq.sv
module xo_bringup_seq
    import xo_seq_pkg::*;
#(
    parameter int TUNE_W  = 8,
    parameter int BIAS_W  = 6,
    parameter int SHUNT_W = 4,
    parameter int TMO_W   = 4,
    parameter int AMP_W   = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               en,
    input  logic               ext_mode,
    input  logic               tick,
    input  logic [TUNE_W-1:0]  start_tune,
    input  logic [BIAS_W-1:0]  start_bias,
    input  logic [TUNE_W-1:0]  steady_tune,
    input  logic [BIAS_W-1:0]  steady_bias,
    input  logic [SHUNT_W-1:0] shunt_init,
    input  logic [TMO_W-1:0]   tmo_startup,
    input  logic [TMO_W-1:0]   tmo_steady,
    input  logic [TMO_W-1:0]   tmo_peak,
    input  logic [TMO_W-1:0]   tmo_shunt,
    input  logic               peak_en,
    input  logic               shunt_en,
    input  logic [AMP_W-1:0]   amp_level,
    input  logic [AMP_W-1:0]   amp_thresh,
    output logic [TUNE_W-1:0]  tune_o,
    output logic [BIAS_W-1:0]  bias_o,
    output logic [SHUNT_W-1:0] shunt_o,
    output logic [2:0]         phase_o,
    output logic               ready_o
);
    localparam logic [BIAS_W-1:0] BIAS_TOP = {BIAS_W{1'b1}};

    xo_phase_e        st, nxt;
    xo_cmd_e          cmd;
    logic             amp_ok;
    logic             tmo_exp;
    logic             restart;
    logic [TMO_W-1:0] tsel;

    xo_amp_cmp #(.AMP_W(AMP_W)) u_cmp (
        .level       (amp_level),
        .thresh      (amp_thresh),
        .at_or_above (amp_ok)
    );

    // timeout code for the phase in progress; external mode uses the minimum
    always_comb begin
        unique case (st)
            PH_STARTUP: tsel = tmo_startup;
            PH_STEADY:  tsel = tmo_steady;
            PH_PEAK:    tsel = tmo_peak;
            PH_SHUNT:   tsel = tmo_shunt;
            default:    tsel = '0;
        endcase
        if (ext_mode) tsel = '0;
    end

    xo_phase_timer #(.TMO_W(TMO_W)) u_tmr (
        .clk     (clk),
        .rst     (rst),
        .restart (restart),
        .tick    (tick),
        .code    (tsel),
        .expire  (tmo_exp)
    );

    always_comb begin
        nxt = st;
        cmd = CMD_HOLD;
        if (!en) begin
            nxt = PH_IDLE;
            cmd = CMD_CLEAR;
        end else begin
            unique case (st)
                PH_IDLE: begin
                    nxt = PH_STARTUP;
                    cmd = CMD_START;
                end
                PH_STARTUP: begin
                    if (tmo_exp) begin
                        nxt = PH_STEADY;
                        cmd = CMD_STEADY;
                    end
                end
                PH_STEADY: begin
                    if (tmo_exp) nxt = after_steady(peak_en, ext_mode);
                end
                PH_PEAK: begin
                    if (tick) begin
                        if (amp_ok || tmo_exp) nxt = after_peak(shunt_en);
                        else                   cmd = CMD_BIAS_UP;
                    end
                end
                PH_SHUNT: begin
                    if (tick) begin
                        if (!amp_ok) begin
                            nxt = PH_READY;
                            cmd = CMD_SHUNT_UP;
                        end else if (shunt_o == '0 || tmo_exp) begin
                            nxt = PH_READY;
                        end else begin
                            cmd = CMD_SHUNT_DN;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign restart = (nxt != st) || (st == PH_IDLE) || (st == PH_READY);

    always_ff @(posedge clk) begin
        if (rst) st <= PH_IDLE;
        else     st <= nxt;
    end

    xo_trim_path #(
        .TUNE_W  (TUNE_W),
        .BIAS_W  (BIAS_W),
        .SHUNT_W (SHUNT_W)
    ) u_trim (
        .clk         (clk),
        .rst         (rst),
        .cmd         (cmd),
        .ext         (ext_mode),
        .start_tune  (start_tune),
        .start_bias  (start_bias),
        .steady_tune (steady_tune),
        .steady_bias (steady_bias),
        .shunt_init  (shunt_init),
        .tune        (tune_o),
        .bias        (bias_o),
        .shunt       (shunt_o)
    );

    assign phase_o = st;
    assign ready_o = (st == PH_READY);

    AST_IDLE_ON_DROP: assert property (@(posedge clk) disable iff (rst)
        !en |=> (phase_o == 3'd0 && !ready_o && tune_o == '0 && bias_o == '0)); // R10

    AST_START_LOAD: assert property (@(posedge clk) disable iff (rst)
        (st == PH_IDLE && en && !ext_mode)
        |=> (phase_o == 3'd1 && tune_o == $past(start_tune) && bias_o == $past(start_bias))); // R2

    AST_EXT_SKIP: assert property (@(posedge clk) disable iff (rst)
        (st == PH_STEADY && en && ext_mode && tmo_exp) |=> (phase_o == 3'd5)); // R9

    AST_SHUNT_ORDER: assert property (@(posedge clk) disable iff (rst)
        (st == PH_SHUNT) |-> ($past(st) == PH_PEAK || $past(st) == PH_SHUNT)); // R8

    AST_BIAS_STEP: assert property (@(posedge clk) disable iff (rst)
        (st == PH_PEAK && en && tick && !amp_ok && !tmo_exp)
        |=> (bias_o == $past(bias_o) + 1'b1 || $past(bias_o) == BIAS_TOP)); // R6

    AST_SHUNT_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (st == PH_SHUNT && en && shunt_o == '0) |=> (shunt_o <= SHUNT_W'(1))); // R12

    AST_READY_FLAG: assert property (@(posedge clk) disable iff (rst)
        ready_o |-> (phase_o == 3'd5)); // R5

endmodule

// File: tb/tb_xo_bringup_seq.sv
module tb_xo_bringup_seq;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       en = 1'b0, ext_mode = 1'b0, tick = 1'b0;
    logic [7:0] start_tune = '0, steady_tune = '0;
    logic [5:0] start_bias = '0, steady_bias = '0;
    logic [3:0] shunt_init = '0;
    logic [3:0] tmo_startup = '0, tmo_steady = '0, tmo_peak = '0, tmo_shunt = '0;
    logic       peak_en = 1'b0, shunt_en = 1'b0;
    logic [7:0] amp_level, amp_thresh = '0;
    logic [7:0] tune_o;
    logic [5:0] bias_o;
    logic [3:0] shunt_o;
    logic [2:0] phase_o;
    logic       ready_o;

    always #4 clk = ~clk;   // 125 MHz

    // amplitude grows with bias and shunt current
    assign amp_level = 8'({2'b00, bias_o} + {3'b000, shunt_o, 1'b0});

    xo_bringup_seq dut (
        .clk(clk), .rst(rst), .en(en), .ext_mode(ext_mode), .tick(tick),
        .start_tune(start_tune), .start_bias(start_bias),
        .steady_tune(steady_tune), .steady_bias(steady_bias),
        .shunt_init(shunt_init),
        .tmo_startup(tmo_startup), .tmo_steady(tmo_steady),
        .tmo_peak(tmo_peak), .tmo_shunt(tmo_shunt),
        .peak_en(peak_en), .shunt_en(shunt_en),
        .amp_level(amp_level), .amp_thresh(amp_thresh),
        .tune_o(tune_o), .bias_o(bias_o), .shunt_o(shunt_o),
        .phase_o(phase_o), .ready_o(ready_o)
    );

    int    checks = 0, failures = 0;
    string cur_req = "R1";
    bit    finished = 0;
    bit    cmp_on = 0;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // tick generator: every tick_div cycles unless held
    int tick_div = 1, tcnt = 0;
    bit tick_hold = 0;
    always @(negedge clk) begin
        if (tick_hold) tick = 1'b0;
        else begin
            tcnt = (tcnt + 1) % tick_div;
            tick = (tcnt == 0);
        end
    end

    // behavioural reference model
    int m_ph = 0, m_tune = 0, m_bias = 0, m_shunt = 0, m_elapsed = 0;
    int code, lim, amp, nph;
    bit ok, done;
    always @(posedge clk) begin
        if (rst || !en) begin
            m_ph = 0; m_tune = 0; m_bias = 0; m_shunt = 0; m_elapsed = 0;
        end else begin
            amp  = (m_bias + 2 * m_shunt) % 256;
            ok   = (amp >= amp_thresh);
            code = ext_mode ? 0 :
                   (m_ph == 1) ? int'(tmo_startup) :
                   (m_ph == 2) ? int'(tmo_steady) :
                   (m_ph == 3) ? int'(tmo_peak) :
                   (m_ph == 4) ? int'(tmo_shunt) : 0;
            lim  = 1 << (code + 1);
            done = tick && (m_elapsed + 1 == lim);
            nph  = m_ph;
            case (m_ph)
                0: begin
                    nph = 1;
                    m_tune  = ext_mode ? 0 : int'(start_tune);
                    m_bias  = ext_mode ? 0 : int'(start_bias);
                    m_shunt = int'(shunt_init);
                end
                1: if (done) begin
                    nph = 2;
                    m_tune = ext_mode ? 0 : int'(steady_tune);
                    m_bias = ext_mode ? 0 : int'(steady_bias);
                end
                2: if (done) nph = (peak_en && !ext_mode) ? 3 : 5;
                3: if (tick) begin
                    if (ok || done) nph = shunt_en ? 4 : 5;
                    else if (m_bias < 63) m_bias++;
                end
                4: if (tick) begin
                    if (!ok) begin
                        nph = 5;
                        if (m_shunt < 15) m_shunt++;
                    end else if (m_shunt == 0 || done) nph = 5;
                    else m_shunt--;
                end
                default: ;
            endcase
            if (nph != m_ph || m_ph == 5) m_elapsed = 0;
            else if (tick) m_elapsed++;
            m_ph = nph;
        end
    end

    // cycle-by-cycle comparison at the falling edge
    bit seen4 = 0;
    always @(negedge clk) begin
        if (cmp_on && !finished) begin
            if (phase_o == 3'd4) seen4 = 1;
            chk(phase_o == 3'(m_ph), cur_req, "phase", int'(phase_o), m_ph);
            chk(ready_o == (m_ph == 5), cur_req, "ready", int'(ready_o), int'(m_ph == 5));
            chk(tune_o == 8'(m_tune), cur_req, "tune", int'(tune_o), m_tune);
            chk(bias_o == 6'(m_bias), cur_req, "bias", int'(bias_o), m_bias);
            chk(shunt_o == 4'(m_shunt), cur_req, "shunt", int'(shunt_o), m_shunt);
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_phase(input int p, input int maxc, input string req);
        int n = 0;
        while (int'(phase_o) != p && n < maxc) begin
            @(negedge clk);
            n++;
        end
        chk(int'(phase_o) == p, req, "phase reached", int'(phase_o), p);
    endtask

    task automatic go_idle();
        en = 1'b0;
        step(2);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n;
        step(4);
        rst = 1'b0;
        cmp_on = 1;
        step(1);
        // R1 reset state
        chk(phase_o == 3'd0 && !ready_o, "R1", "phase", int'(phase_o), 0);
        chk(tune_o == 0 && bias_o == 0 && shunt_o == 0, "R1", "codes", int'(tune_o) + int'(bias_o), 0);

        // R2 R3 R4 R5 R11: plain crystal bring-up, one tick per cycle
        cur_req = "R4";
        start_tune = 8'h55; start_bias = 6'd10; steady_tune = 8'h33; steady_bias = 6'd20;
        shunt_init = 4'd5; tmo_startup = 4'd2; tmo_steady = 4'd1;
        en = 1'b1;
        step(1);
        chk(phase_o == 3'd1, "R2", "phase", int'(phase_o), 1);
        chk(tune_o == 8'h55 && bias_o == 6'd10, "R2", "start tune", int'(tune_o), 'h55);
        chk(shunt_o == 4'd5, "R2", "shunt", int'(shunt_o), 5);
        n = 0;
        while (phase_o == 3'd1 && n < 100) begin n++; step(1); end
        chk(n == 8, "R3", "startup cycles", n, 8);
        chk(phase_o == 3'd2, "R11", "steady phase code", int'(phase_o), 2);
        chk(tune_o == 8'h33 && bias_o == 6'd20, "R4", "steady tune", int'(tune_o), 'h33);
        n = 0;
        while (phase_o == 3'd2 && n < 100) begin n++; step(1); end
        chk(n == 4, "R4", "steady cycles", n, 4);
        chk(phase_o == 3'd5 && ready_o, "R5", "ready", int'(ready_o), 1);
        go_idle();

        // R3 tick gating
        cur_req = "R3";
        tick_hold = 1;
        en = 1'b1;
        step(40);
        chk(phase_o == 3'd1, "R3", "phase without ticks", int'(phase_o), 1);
        tick_hold = 0;
        go_idle();

        // R6 R7: peak then shunt, ticks every third cycle
        cur_req = "R7";
        tick_div = 3;
        peak_en = 1; shunt_en = 1; amp_thresh = 8'd40;
        tmo_peak = 4'd4; tmo_shunt = 4'd3;
        en = 1'b1;
        wait_phase(3, 200, "R11");
        wait_phase(4, 200, "R7");
        wait_phase(5, 200, "R7");
        chk(bias_o == 6'd30, "R6", "bias after peak", int'(bias_o), 30);
        chk(shunt_o == 4'd5, "R7", "shunt restored", int'(shunt_o), 5);
        go_idle();

        // R10: drop enable in peak detection, then re-enable
        cur_req = "R10";
        tick_div = 1;
        amp_thresh = 8'd90; tmo_peak = 4'd6;
        en = 1'b1;
        wait_phase(3, 100, "R10");
        step(3);
        en = 1'b0;
        step(1);
        chk(phase_o == 3'd0 && !ready_o, "R10", "phase after drop", int'(phase_o), 0);
        chk(tune_o == 0 && bias_o == 0 && shunt_o == 0, "R10", "codes after drop", int'(bias_o), 0);
        en = 1'b1;
        step(1);
        chk(tune_o == 8'h55 && bias_o == 6'd10, "R10", "reload start bias", int'(bias_o), 10);
        go_idle();

        // R6: peak timeout ends stepping after three steps
        cur_req = "R6";
        tmo_peak = 4'd1; shunt_en = 0;
        en = 1'b1;
        wait_phase(5, 100, "R6");
        chk(bias_o == 6'd23, "R6", "bias at timeout", int'(bias_o), 23);
        go_idle();

        // R8: shunt enabled without peak
        cur_req = "R8";
        peak_en = 0; shunt_en = 1; amp_thresh = 8'd0;
        seen4 = 0;
        en = 1'b1;
        wait_phase(5, 100, "R8");
        chk(!seen4, "R8", "shunt phase seen", int'(seen4), 0);
        chk(shunt_o == 4'd5, "R8", "shunt kept", int'(shunt_o), 5);
        go_idle();

        // R9: external clock mode
        cur_req = "R9";
        ext_mode = 1; peak_en = 1; shunt_en = 1;
        tmo_startup = 4'd10; tmo_steady = 4'd10; amp_thresh = 8'd90;
        en = 1'b1;
        step(1);
        chk(tune_o == 0 && bias_o == 0, "R9", "ext codes", int'(tune_o), 0);
        n = 0;
        while (phase_o != 3'd5 && n < 100) begin n++; step(1); end
        chk(n == 4, "R9", "ext cycles to ready", n, 4);
        go_idle();
        ext_mode = 0;
        tmo_startup = 4'd1; tmo_steady = 4'd0;

        // R12: bias saturation
        cur_req = "R12";
        steady_bias = 6'd60; amp_thresh = 8'd200; tmo_peak = 4'd3; shunt_en = 0;
        en = 1'b1;
        wait_phase(5, 200, "R12");
        chk(bias_o == 6'd63, "R12", "bias saturated", int'(bias_o), 63);
        go_idle();

        // R12: shunt floor
        steady_bias = 6'd20; shunt_init = 4'd3; amp_thresh = 8'd0;
        shunt_en = 1; tmo_shunt = 4'd4;
        en = 1'b1;
        wait_phase(5, 200, "R12");
        chk(shunt_o == 4'd0, "R12", "shunt floor", int'(shunt_o), 0);
        go_idle();

        step(2);
        finish_run();
    end

endmodule